// File: doc/BRIEF.md
# Scatter-gather DMA engine

This engine runs one copy command at a time. A command holds a direction, an element count and the word address of an element list kept in local memory. Each list element takes three consecutive 32-bit words: the local byte address, the remote byte address and the byte length of one block. The engine walks the list in order. For each element it reads the three words, checks them, and then moves the block one 32-bit word at a time between the local and remote memory ports. A "get" copies from remote to local. A "put" copies from local to remote.

A count of one is a single-block command. Any count from 2 to the list limit chains that many blocks, and they behave as consecutive single transfers. The engine reports the whole command once, at the end: a one-cycle `done` pulse, or a one-cycle `fail` pulse with a held reason code. Both memory ports use a request/ready handshake. A read returns its data in the same cycle as the handshake.

Top module: `sgdma_engine`

## Requirements
- R1: While reset is asserted, busy, done, fail, loc_req and rem_req are low, and fail_code is 0.
- R2: A command whose count is 0 or above 2048 ends with a fail pulse and fail_code 1, and it issues no memory request.
- R3: For list element i, the engine reads local words base+12i, base+12i+4 and base+12i+8, in that order, as local address, remote address and byte size. The engine handles elements in list order, and it fetches each element only after the previous block has finished.
- R4: With cmd_dir 0 (get), size/4 words are copied from ascending remote addresses to ascending local addresses.
- R5: With cmd_dir 1 (put), size/4 words are copied from ascending local addresses to ascending remote addresses.
- R6: An element whose size is 0 or above 16384 gives fail_code 2. A size of exactly 16384 is accepted.
- R7: A list base, local address, remote address or size that is not a multiple of 4 gives fail_code 3. The size range test of R6 takes precedence over this test.
- R8: A word moves only in a cycle where req and rdy are both high on its port. While a request waits without rdy, its address, write enable and write data stay unchanged.
- R9: busy is high from the cycle after a command is accepted up to and including the cycle of its done or fail pulse. cmd_wr is ignored in every cycle where busy is high.
- R10: Each good command gives exactly one single-cycle done pulse, with fail_code 0. done and fail are never high together.
- R11: After an error the engine makes no further memory request. Blocks copied before the error stay in place, and fail_code holds its value until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Command write strobe, taken only when idle |
| cmd_dir | input | 1 | 0 = get (remote to local), 1 = put (local to remote) |
| cmd_len | input | 13 | Number of list elements |
| cmd_list | input | 32 | Byte address of the element list in local memory |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: command finished without error |
| fail | output | 1 | One-cycle pulse: command aborted |
| fail_code | output | 2 | 0 none, 1 bad count, 2 bad size, 3 misaligned |
| loc_req | output | 1 | Local port request |
| loc_we | output | 1 | Local port write enable |
| loc_addr | output | 32 | Local port byte address |
| loc_wdata | output | 32 | Local port write data |
| loc_rdy | input | 1 | Local port ready |
| loc_rdata | input | 32 | Local port read data, valid with loc_rdy |
| rem_req | output | 1 | Remote port request |
| rem_we | output | 1 | Remote port write enable |
| rem_addr | output | 32 | Remote port byte address |
| rem_wdata | output | 32 | Remote port write data |
| rem_rdy | input | 1 | Remote port ready |
| rem_rdata | input | 32 | Remote port read data, valid with rem_rdy |

## Verification
A new command write can arrive in the same cycle that the engine pulses done for the previous command. The bench provokes this by raising cmd_wr on the very cycle it sees done, and holding it for one more cycle. It then checks that busy is still low one cycle later, so the write made during the pulse had no effect. It also checks that the held write is taken exactly once, in the following idle cycle; that command has a zero count, so acceptance shows up as a fail pulse with code 1. In a separate run, cmd_wr is held high for a whole list with a different command attached, and comparing both memories against the model shows that the other command never ran.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_DONE, ST_FAIL
  } sg_state_t;

  typedef enum logic [1:0] {
    CODE_OK    = 2'd0,
    CODE_COUNT = 2'd1,
    CODE_SIZE  = 2'd2,
    CODE_ALIGN = 2'd3
  } sg_code_t;

  localparam logic PORT_LOCAL  = 1'b0;
  localparam logic PORT_REMOTE = 1'b1;
  localparam logic DIR_GET     = 1'b0;
  localparam logic DIR_PUT     = 1'b1;
endpackage

// File: rtl/sgdma_elem_check.sv
`timescale 1ns/1ps
module sgdma_elem_check
  import sgdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 16384
) (
  input  logic [AW-1:0] loc_addr,
  input  logic [AW-1:0] rem_addr,
  input  logic [AW-1:0] size,
  output logic          ok,
  output sg_code_t      code
);
  localparam logic [AW-1:0] SIZE_LIMIT = AW'(MAX_BYTES);

  logic size_bad;
  logic align_bad;

  always_comb begin
    size_bad  = (size == '0) || (size > SIZE_LIMIT);
    align_bad = |{loc_addr[1:0], rem_addr[1:0], size[1:0]};
    if (size_bad)       code = CODE_SIZE;
    else if (align_bad) code = CODE_ALIGN;
    else                code = CODE_OK;
    ok = (code == CODE_OK);
  end
endmodule

// File: rtl/sgdma_port_mux.sv
`timescale 1ns/1ps
module sgdma_port_mux
  import sgdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_req,
  input  logic                op_port,
  input  logic                op_we,
  input  logic [AW-1:0]       op_addr,
  input  logic [DW-1:0]       op_wdata,
  output logic                op_ack,
  output logic [DW-1:0]       op_rdata,
  output logic [1:0]          p_req,
  output logic [1:0]          p_we,
  output logic [1:0][AW-1:0]  p_addr,
  output logic [1:0][DW-1:0]  p_wdata,
  input  logic [1:0]          p_rdy,
  input  logic [1:0][DW-1:0]  p_rdata
);
  localparam int NPORT = 2;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign p_req[g]   = op_req && (op_port == 1'(g));
    assign p_we[g]    = p_req[g] && op_we;
    assign p_addr[g]  = p_req[g] ? op_addr : '0;
    assign p_wdata[g] = (p_req[g] && op_we) ? op_wdata : '0;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req[g] && !p_rdy[g]) |=>
        (p_req[g] && $stable(p_addr[g]) && $stable(p_we[g]) && $stable(p_wdata[g])));
  end

  assign op_ack   = |(p_req & p_rdy);
  assign op_rdata = p_rdata[op_port];
endmodule

// File: rtl/sgdma_ctrl.sv
`timescale 1ns/1ps
module sgdma_ctrl
  import sgdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_LIST  = 2048,
  parameter int MAX_BYTES = 16384,
  localparam int LEN_W    = $clog2(MAX_LIST) + 2,
  localparam int SW       = $clog2(MAX_BYTES / 4) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             cmd_dir,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [AW-1:0]    cmd_list,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output sg_code_t         fail_code,
  output logic             op_req,
  output logic             op_port,
  output logic             op_we,
  output logic [AW-1:0]    op_addr,
  output logic [DW-1:0]    op_wdata,
  input  logic             op_ack,
  input  logic [DW-1:0]    op_rdata,
  output logic [AW-1:0]    e_loc,
  output logic [AW-1:0]    e_rem,
  output logic [AW-1:0]    e_size,
  input  logic             chk_ok,
  input  sg_code_t         chk_code
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  sg_state_t        state_q, state_d;
  logic             dir_q, dir_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic [1:0]       fw_q, fw_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [AW-1:0]    src_q, src_d;
  logic [AW-1:0]    dst_q, dst_d;
  logic [SW-1:0]    left_q, left_d;
  sg_code_t         code_q, code_d;
  logic [AW-1:0]    e_loc_q, e_rem_q, e_size_q;
  logic [DW-1:0]    buf_q;
  logic             fetch_en;
  logic             buf_en;

  // next-state process
  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    len_d    = len_q;
    idx_d    = idx_q;
    fw_d     = fw_q;
    ptr_d    = ptr_q;
    src_d    = src_q;
    dst_d    = dst_q;
    left_d   = left_q;
    code_d   = code_q;
    op_req   = 1'b0;
    op_port  = PORT_LOCAL;
    op_we    = 1'b0;
    op_addr  = '0;
    op_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          dir_d  = cmd_dir;
          len_d  = cmd_len;
          ptr_d  = cmd_list;
          idx_d  = '0;
          fw_d   = '0;
          code_d = CODE_OK;
          if ((cmd_len == '0) || (cmd_len > LEN_W'(MAX_LIST))) begin
            code_d  = CODE_COUNT;
            state_d = ST_FAIL;
          end else if (cmd_list[1:0] != 2'b00) begin
            code_d  = CODE_ALIGN;
            state_d = ST_FAIL;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        op_req  = 1'b1;
        op_addr = ptr_q;
        if (op_ack) begin
          ptr_d = ptr_q + WORD_STEP;
          if (fw_q == 2'd2) begin
            fw_d    = '0;
            state_d = ST_CHECK;
          end else begin
            fw_d = fw_q + 2'd1;
          end
        end
      end
      ST_CHECK: begin
        if (!chk_ok) begin
          code_d  = chk_code;
          state_d = ST_FAIL;
        end else begin
          left_d  = SW'(e_size_q >> 2);
          src_d   = (dir_q == DIR_PUT) ? e_loc_q : e_rem_q;
          dst_d   = (dir_q == DIR_PUT) ? e_rem_q : e_loc_q;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        op_req  = 1'b1;
        op_port = (dir_q == DIR_PUT) ? PORT_LOCAL : PORT_REMOTE;
        op_addr = src_q;
        if (op_ack) begin
          src_d   = src_q + WORD_STEP;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        op_req   = 1'b1;
        op_port  = (dir_q == DIR_PUT) ? PORT_REMOTE : PORT_LOCAL;
        op_we    = 1'b1;
        op_addr  = dst_q;
        op_wdata = buf_q;
        if (op_ack) begin
          dst_d  = dst_q + WORD_STEP;
          left_d = left_q - SW'(1);
          if (left_q == SW'(1)) begin
            if ((idx_q + LEN_W'(1)) == len_q) begin
              state_d = ST_DONE;
            end else begin
              idx_d   = idx_q + LEN_W'(1);
              state_d = ST_FETCH;
            end
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_GET;
      len_q   <= '0;
      idx_q   <= '0;
      fw_q    <= '0;
      ptr_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      code_q  <= CODE_OK;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      fw_q    <= fw_d;
      ptr_q   <= ptr_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      left_q  <= left_d;
      code_q  <= code_d;
    end
  end

  // datapath registers with explicit clock enables
  assign fetch_en = (state_q == ST_FETCH) && op_ack;
  assign buf_en   = (state_q == ST_READ) && op_ack;

  always_ff @(posedge clk) begin
    if (fetch_en && (fw_q == 2'd0)) e_loc_q  <= op_rdata;
    if (fetch_en && (fw_q == 2'd1)) e_rem_q  <= op_rdata;
    if (fetch_en && (fw_q == 2'd2)) e_size_q <= op_rdata;
    if (buf_en)                     buf_q    <= op_rdata;
  end

  assign e_loc     = e_loc_q;
  assign e_rem     = e_rem_q;
  assign e_size    = e_size_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign fail      = (state_q == ST_FAIL);
  assign fail_code = code_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R11
  quiet_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !op_req);

  // R6 R7
  elem_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CHECK) && !chk_ok) |=> (fail && (fail_code == $past(chk_code))));
endmodule

// File: rtl/sgdma_engine.sv
`timescale 1ns/1ps
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_LIST  = 2048,
  parameter int MAX_BYTES = 16384,
  localparam int DW       = 32,
  localparam int LEN_W    = $clog2(MAX_LIST) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             cmd_dir,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [AW-1:0]    cmd_list,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [1:0]       fail_code,
  output logic             loc_req,
  output logic             loc_we,
  output logic [AW-1:0]    loc_addr,
  output logic [DW-1:0]    loc_wdata,
  input  logic             loc_rdy,
  input  logic [DW-1:0]    loc_rdata,
  output logic             rem_req,
  output logic             rem_we,
  output logic [AW-1:0]    rem_addr,
  output logic [DW-1:0]    rem_wdata,
  input  logic             rem_rdy,
  input  logic [DW-1:0]    rem_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic            op_req, op_port, op_we, op_ack;
  logic [AW-1:0]   op_addr;
  logic [DW-1:0]   op_wdata, op_rdata;
  logic [AW-1:0]   e_loc, e_rem, e_size;
  logic            chk_ok;
  sg_code_t        chk_code, code;
  logic [1:0]          p_req, p_we, p_rdy;
  logic [1:0][AW-1:0]  p_addr;
  logic [1:0][DW-1:0]  p_wdata, p_rdata;

  sgdma_ctrl #(
    .AW(AW), .DW(DW), .MAX_LIST(MAX_LIST), .MAX_BYTES(MAX_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .cmd_wr(cmd_wr), .cmd_dir(cmd_dir), .cmd_len(cmd_len), .cmd_list(cmd_list),
    .busy(busy), .done(done), .fail(fail), .fail_code(code),
    .op_req(op_req), .op_port(op_port), .op_we(op_we), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_ack(op_ack), .op_rdata(op_rdata),
    .e_loc(e_loc), .e_rem(e_rem), .e_size(e_size),
    .chk_ok(chk_ok), .chk_code(chk_code)
  );

  sgdma_elem_check #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_check (
    .loc_addr(e_loc), .rem_addr(e_rem), .size(e_size),
    .ok(chk_ok), .code(chk_code)
  );

  sgdma_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_core_n),
    .op_req(op_req), .op_port(op_port), .op_we(op_we), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_ack(op_ack), .op_rdata(op_rdata),
    .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rdy(p_rdy), .p_rdata(p_rdata)
  );

  // index 0 is the local port, index 1 the remote port
  assign loc_req    = p_req[0];
  assign loc_we     = p_we[0];
  assign loc_addr   = p_addr[0];
  assign loc_wdata  = p_wdata[0];
  assign rem_req    = p_req[1];
  assign rem_we     = p_we[1];
  assign rem_addr   = p_addr[1];
  assign rem_wdata  = p_wdata[1];
  assign p_rdy      = {rem_rdy, loc_rdy};
  assign p_rdata[0] = loc_rdata;
  assign p_rdata[1] = rem_rdata;
  assign fail_code  = code;

  // R2
  bad_count_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd_wr && !busy && ((cmd_len == '0) || (cmd_len > LEN_W'(MAX_LIST))))
      |=> (fail && (fail_code == 2'd1)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> !(loc_req || rem_req));
endmodule

// File: tb/sgdma_engine_test.sv
`timescale 1ns/1ps
module sgdma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr, cmd_dir;
  logic [12:0] cmd_len;
  logic [31:0] cmd_list;
  logic        busy, done, fail;
  logic [1:0]  fail_code;
  logic        loc_req, loc_we, loc_rdy, rem_req, rem_we, rem_rdy;
  logic [31:0] loc_addr, loc_wdata, loc_rdata, rem_addr, rem_wdata, rem_rdata;

  always #2.5 clk = ~clk;

  sgdma_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_dir(cmd_dir),
    .cmd_len(cmd_len), .cmd_list(cmd_list), .busy(busy), .done(done),
    .fail(fail), .fail_code(fail_code),
    .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdy(loc_rdy), .loc_rdata(loc_rdata),
    .rem_req(rem_req), .rem_we(rem_we), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
    .rem_rdy(rem_rdy), .rem_rdata(rem_rdata)
  );

  logic [31:0] lm [8192];
  logic [31:0] rm [4096];
  logic [31:0] sl [8192];
  logic [31:0] sr [4096];
  logic [31:0] la [3];
  int lh, rh, rdy_pct, checks, failures;

  assign loc_rdata = lm[loc_addr[14:2]];
  assign rem_rdata = rm[rem_addr[13:2]];

  always @(posedge clk) begin
    if (loc_req && loc_rdy) begin
      if (loc_we) lm[loc_addr[14:2]] = loc_wdata;
      else if (lh < 3) la[lh] = loc_addr;
      lh = lh + 1;
    end
    if (rem_req && rem_rdy) begin
      if (rem_we) rm[rem_addr[13:2]] = rem_wdata;
      rh = rh + 1;
    end
  end

  always @(negedge clk) begin
    loc_rdy = int'($urandom % 100) < rdy_pct;
    rem_rdy = int'($urandom % 100) < rdy_pct;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_elem(input logic [31:0] base, input int i,
                          input logic [31:0] l, input logic [31:0] r, input logic [31:0] s);
    logic [31:0] a;
    a = base + 32'(12 * i);
    lm[a[14:2]] = l;
    a = a + 4; lm[a[14:2]] = r;
    a = a + 4; lm[a[14:2]] = s;
  endtask

  function automatic logic [31:0] srd(input logic [31:0] a);
    return sl[a[14:2]];
  endfunction

  // expected behaviour from the requirements, on shadow memories
  task automatic model(input logic dir, input logic [12:0] n, input logic [31:0] base,
                       output logic [1:0] code, output int el, output int er);
    logic [31:0] p, l, r, s;
    el = 0; er = 0; code = 2'd0;
    if (n == 0 || n > 2048) begin code = 2'd1; return; end
    if (base[1:0] != 0) begin code = 2'd3; return; end
    p = base;
    for (int i = 0; i < int'(n); i++) begin
      l = srd(p); r = srd(p + 4); s = srd(p + 8);
      p = p + 12; el += 3;
      if (s == 0 || s > 16384) begin code = 2'd2; return; end
      if ((l[1:0] | r[1:0] | s[1:0]) != 0) begin code = 2'd3; return; end
      for (int w = 0; w < int'(s >> 2); w++) begin
        if (dir == 1'b0) sl[l[14:2]] = sr[r[13:2]];
        else             sr[r[13:2]] = sl[l[14:2]];
        l = l + 4; r = r + 4; el++; er++;
      end
    end
  endtask

  task automatic run_cmd(input string tag, input logic dir, input logic [12:0] n,
                         input logic [31:0] base, input bit decoy, input bit chain);
    logic [1:0] ec;
    int el, er, waited, mis;
    string rq;
    for (int i = 0; i < 8192; i++) sl[i] = lm[i];
    for (int i = 0; i < 4096; i++) sr[i] = rm[i];
    model(dir, n, base, ec, el, er);
    rq = (ec == 2'd1) ? "R2" : (ec == 2'd2) ? "R6" : (ec == 2'd3) ? "R7" : "R10";
    lh = 0; rh = 0;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_dir = dir; cmd_len = n; cmd_list = base;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy == 1'b1, "R9", {tag, " busy after accept"}, busy, 1);
    if (decoy) begin
      cmd_wr = 1'b1; cmd_dir = 1'b0; cmd_len = 13'd1; cmd_list = 32'h7800;
    end
    waited = 0;
    while (!(done || fail) && waited < 60000) begin
      @(negedge clk); waited++;
    end
    cmd_wr = 1'b0;
    if (chain) begin cmd_wr = 1'b1; cmd_len = 13'd0; cmd_list = 32'h0; end
    chk(done == (ec == 2'd0), rq, {tag, " done"}, done, ec == 2'd0);
    chk(fail == (ec != 2'd0), rq, {tag, " fail"}, fail, ec != 2'd0);
    chk(fail_code == ec, rq, {tag, " fail_code"}, fail_code, ec);
    @(negedge clk);
    // R9 R10: pulse lasts one cycle and a write in the pulse cycle is ignored
    chk(!done && !fail && !busy, "R10", {tag, " single pulse, idle after"},
        {done, fail, busy}, 0);
    chk(fail_code == ec, "R11", {tag, " fail_code held"}, fail_code, ec);
    if (chain) begin
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(fail && fail_code == 2'd1, "R9", {tag, " write after pulse taken once"},
          {fail, fail_code}, 3'b101);
      @(negedge clk);
    end
    chk(lh == el, "R3", {tag, " local handshakes"}, lh, el);
    chk(rh == er, "R8", {tag, " remote handshakes"}, rh, er);
    if (el >= 3)
      chk(la[0] == base && la[1] == base + 4 && la[2] == base + 8, "R3",
          {tag, " fetch order"}, la[2], base + 8);
    mis = 0;
    for (int i = 0; i < 8192; i++) if (lm[i] !== sl[i]) mis++;
    chk(mis == 0, (ec != 0) ? "R11" : "R4", {tag, " local memory"}, mis, 0);
    mis = 0;
    for (int i = 0; i < 4096; i++) if (rm[i] !== sr[i]) mis++;
    chk(mis == 0, (ec != 0) ? "R11" : "R5", {tag, " remote memory"}, mis, 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] base;
    void'($urandom(32'd4242));
    checks = 0; failures = 0; lh = 0; rh = 0; rdy_pct = 100;
    cmd_wr = 1'b0; cmd_dir = 1'b0; cmd_len = '0; cmd_list = '0;
    for (int i = 0; i < 8192; i++) lm[i] = $urandom;
    for (int i = 0; i < 4096; i++) rm[i] = $urandom;
    rst_n = 1'b0;
    #1;
    // R1
    chk(!busy && !done && !fail && !loc_req && !rem_req && fail_code == 0, "R1",
        "reset state", {busy, done, fail, loc_req, rem_req, fail_code}, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !loc_req && !rem_req, "R1", "reset held", {busy, loc_req, rem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: largest block, get direction
    set_elem(32'h7000, 0, 32'h0, 32'h0, 32'd16384);
    run_cmd("max block get", 1'b0, 13'd1, 32'h7000, 1'b0, 1'b0);

    // R5 R9: put list with a competing command held on cmd_wr throughout
    rdy_pct = 70;
    set_elem(32'h7800, 0, 32'h100, 32'h200, 32'd16);
    for (int i = 0; i < 3; i++)
      set_elem(32'h6100, i, 32'h1000 + 32'(i * 64), 32'h2000 + 32'(i * 64), 32'd32);
    run_cmd("put with decoy", 1'b1, 13'd3, 32'h6100, 1'b1, 1'b0);

    // R6 R11: second element too large, first stays copied
    set_elem(32'h6200, 0, 32'h1400, 32'h0300, 32'd24);
    set_elem(32'h6200, 1, 32'h1500, 32'h0400, 32'd16388);
    set_elem(32'h6200, 2, 32'h1600, 32'h0500, 32'd8);
    run_cmd("size over limit", 1'b0, 13'd3, 32'h6200, 1'b0, 1'b0);

    // R6: zero size
    set_elem(32'h6300, 0, 32'h1400, 32'h0300, 32'd0);
    run_cmd("zero size", 1'b1, 13'd2, 32'h6300, 1'b0, 1'b0);

    // R7: misaligned local address on element 1
    set_elem(32'h6400, 0, 32'h1800, 32'h0800, 32'd12);
    set_elem(32'h6400, 1, 32'h1902, 32'h0900, 32'd12);
    run_cmd("misaligned local", 1'b1, 13'd2, 32'h6400, 1'b0, 1'b0);

    // R7: size not a multiple of 4
    set_elem(32'h6500, 0, 32'h1800, 32'h0800, 32'd6);
    run_cmd("odd size", 1'b0, 13'd1, 32'h6500, 1'b0, 1'b0);

    // R7: misaligned list base
    run_cmd("misaligned base", 1'b0, 13'd1, 32'h6502, 1'b0, 1'b0);

    // R2: count limits
    run_cmd("count zero", 1'b0, 13'd0, 32'h6500, 1'b0, 1'b0);
    run_cmd("count 2049", 1'b1, 13'd2049, 32'h6500, 1'b0, 1'b0);

    // R9 R10: command write in the same cycle as done
    set_elem(32'h6600, 0, 32'h1A00, 32'h0A00, 32'd8);
    set_elem(32'h6600, 1, 32'h1B00, 32'h0B00, 32'd4);
    run_cmd("write during done", 1'b0, 13'd2, 32'h6600, 1'b0, 1'b1);

    // R3 R4 R5 R8: random lists, random ready
    for (int it = 0; it < 12; it++) begin
      int n;
      logic d;
      d = 1'($urandom % 2);
      n = ($urandom % 4 == 0) ? 1 : 2 + int'($urandom % 5);
      base = 32'h6000 + 32'(($urandom % 256) * 4);
      rdy_pct = 40 + int'($urandom % 60);
      for (int i = 0; i < n; i++)
        set_elem(base, i, 32'(($urandom % 5000) * 4), 32'(($urandom % 4000) * 4),
                 32'(4 * (1 + $urandom % 16)));
      run_cmd($sformatf("random %0d", it), d, 13'(n), base, 1'b0, 1'b0);
    end

    // R3: longest list
    rdy_pct = 100;
    for (int i = 0; i < 2048; i++)
      set_elem(32'h2000, i, 32'(4 * i), 32'((4 * i) & 32'h3FFC), 32'd4);
    run_cmd("count 2048", 1'b1, 13'd2048, 32'h2000, 1'b0, 1'b0);

    summary();
    $finish;
  end
endmodule